// File: doc/BRIEF.md
# ADC Result DMA Sequencer

This block moves conversion results from a scanning multi-channel ADC into the register file without CPU involvement. The ADC raises a one-cycle ready strobe with a 16-bit result for the input it has just converted. The sequencer captures that result and raises a bus request to the CPU. It then waits for the acknowledge and writes the result as two consecutive bytes at a programmable base address plus twice the input number, high byte first. After the writes it gives the bus back.

After each transfer the sequencer advances the ADC to the next input and pulses a conversion start. When the input just stored is the highest one configured, it returns to input 0 and starts a conversion there instead. If enabled, it also pulses an interrupt request at that moment. Ready strobes that arrive while a transfer is under way are dropped.

Top module: `adc_scan_dma`

## Requirements
- R1: While reset is applied and in the first cycle after it, bus_req, wr_en, adc_start and irq are 0 and adc_ch is 0.
- R2: An adc_ready strobe in a cycle with no transfer in progress makes bus_req 1 from the next cycle. bus_req stays 1, with wr_en 0, for every cycle until bus_ack has been sampled 1 at a rising edge.
- R3: In the cycle after bus_ack is sampled, wr_en is 1 with wr_addr = cfg_base + 2*adc_ch and wr_data = result bits [15:8]. In the next cycle wr_en is 1 with wr_addr one higher and wr_data = result bits [7:0].
- R4: bus_req and wr_en fall to 0 in the cycle that follows the second write.
- R5: When the stored input is below cfg_last_ch, adc_ch becomes the stored input plus 1 in the cycle after the second write. adc_start is 1 in that cycle only.
- R6: When the stored input is greater than or equal to cfg_last_ch, adc_ch becomes 0 in the cycle after the second write, and adc_start is 1 in that cycle only.
- R7: irq is 1 for exactly the cycle of an R6 wrap when cfg_irq_en is 1. It is 0 at every other time, including wraps with cfg_irq_en at 0.
- R8: An adc_ready strobe that arrives while bus_req is 1 is ignored. No further request or write follows it.
- R9: With cfg_last_ch = 0, every transfer writes to cfg_base and cfg_base+1, and adc_ch stays 0.
- R10: The bytes written are the adc_data value present with the accepted ready strobe. Later changes of adc_data have no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 12 | Register-file address for input 0, high byte |
| cfg_last_ch | input | 4 | Highest input number in the scan |
| cfg_irq_en | input | 1 | Enables the interrupt pulse on scan wrap |
| adc_ready | input | 1 | One-cycle strobe: result for adc_ch is valid |
| adc_data | input | 16 | Conversion result |
| adc_ch | output | 4 | Input number to be converted / being stored |
| adc_start | output | 1 | One-cycle conversion start for adc_ch |
| bus_req | output | 1 | System bus request to the CPU |
| bus_ack | input | 1 | System bus grant from the CPU |
| wr_en | output | 1 | Register-file byte write strobe |
| wr_addr | output | 12 | Register-file byte address |
| wr_data | output | 8 | Register-file write byte |
| irq | output | 1 | One-cycle interrupt request on scan wrap |

## Verification
The hardest case to reach is a ready strobe that overlaps a transfer still in progress. From the ports it can only be created by pulsing adc_ready after a result has already been accepted, while the CPU is still holding off the acknowledge or the bytes are being written. The stimulus table therefore has a flag that fires a second strobe during the high-byte write cycle. It also varies how long bus_ack is held back. After each such transfer the bench confirms that the bus request stays low and that no write appears. The stimulus also changes adc_data straight after the accepted strobe, so that a design which sampled the result late would write the wrong bytes.

// File: rtl/adc_dma_pkg.sv
package adc_dma_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_WAIT = 2'd1,
      XS_HI   = 2'd2,
      XS_LO   = 2'd3
   } xfer_state_t;

endpackage

// File: rtl/adc_dma_xfer_fsm.sv
module adc_dma_xfer_fsm
   import adc_dma_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        adc_ready,
   input  logic        bus_ack,
   output logic        capture,
   output logic        second,
   output logic        done,
   output logic        bus_req,
   output logic        wr_en
);

   xfer_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         XS_IDLE: if (adc_ready) state_d = XS_WAIT;
         XS_WAIT: if (bus_ack)   state_d = XS_HI;
         XS_HI:                  state_d = XS_LO;
         XS_LO:                  state_d = XS_IDLE;
         default:                state_d = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= XS_IDLE;
      else        state_q <= state_d;
   end

   assign capture = (state_q == XS_IDLE) && adc_ready;
   assign second  = (state_q == XS_LO);
   assign done    = (state_q == XS_LO);
   assign bus_req = (state_q != XS_IDLE);
   assign wr_en   = (state_q == XS_HI) || (state_q == XS_LO);

endmodule

// File: rtl/adc_dma_chan_seq.sv
module adc_dma_chan_seq #(
   parameter int CH_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            done,
   input  logic [CH_W-1:0] cfg_last_ch,
   input  logic            cfg_irq_en,
   output logic [CH_W-1:0] ch,
   output logic            start,
   output logic            irq
);

   logic wrap;
   assign wrap = (ch >= cfg_last_ch);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch    <= '0;
         start <= 1'b0;
         irq   <= 1'b0;
      end else if (done) begin
         ch    <= wrap ? '0 : ch + 1'b1;
         start <= 1'b1;
         irq   <= wrap & cfg_irq_en;
      end else begin
         start <= 1'b0;
         irq   <= 1'b0;
      end
   end

endmodule

// File: rtl/adc_dma_wr_path.sv
module adc_dma_wr_path #(
   parameter int ADDR_W   = 12,
   parameter int BYTE_W   = 8,
   parameter int CH_W     = 4,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                capture,
   input  logic [2*BYTE_W-1:0] adc_data,
   input  logic                second,
   input  logic [ADDR_W-1:0]   cfg_base,
   input  logic [CH_W-1:0]     ch,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [BYTE_W-1:0]   wr_data
);

   localparam int RES_W = 2 * BYTE_W;
   localparam int PAD_W = ADDR_W - CH_W - 1;

   logic [RES_W-1:0]  result_q;
   logic [BYTE_W-1:0] hi_byte, lo_byte;
   logic [ADDR_W-1:0] pair_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       result_q <= '0;
      else if (capture) result_q <= adc_data;
   end

   assign hi_byte   = result_q[RES_W-1:BYTE_W];
   assign lo_byte   = result_q[BYTE_W-1:0];
   assign pair_addr = cfg_base + {{PAD_W{1'b0}}, ch, 1'b0};
   assign wr_addr   = pair_addr + {{(ADDR_W-1){1'b0}}, second};

   generate
      if (HI_FIRST) begin : g_hi_first
         assign wr_data = second ? lo_byte : hi_byte;
      end else begin : g_lo_first
         assign wr_data = second ? hi_byte : lo_byte;
      end
   endgenerate

endmodule

// File: rtl/adc_scan_dma.sv
module adc_scan_dma #(
   parameter int ADDR_W   = 12,
   parameter int BYTE_W   = 8,
   parameter int CH_W     = 4,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   cfg_base,
   input  logic [CH_W-1:0]     cfg_last_ch,
   input  logic                cfg_irq_en,
   input  logic                adc_ready,
   input  logic [2*BYTE_W-1:0] adc_data,
   output logic [CH_W-1:0]     adc_ch,
   output logic                adc_start,
   output logic                bus_req,
   input  logic                bus_ack,
   output logic                wr_en,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [BYTE_W-1:0]   wr_data,
   output logic                irq
);

   generate
      if (CH_W < 1) begin : g_bad_ch
         $error("adc_scan_dma: CH_W must be at least 1");
      end
      if (ADDR_W < CH_W + 2) begin : g_bad_addr
         $error("adc_scan_dma: ADDR_W too small for the channel offset");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("adc_scan_dma: BYTE_W must be at least 1");
      end
   endgenerate

   logic capture, second, done;

   adc_dma_xfer_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .adc_ready (adc_ready),
      .bus_ack   (bus_ack),
      .capture   (capture),
      .second    (second),
      .done      (done),
      .bus_req   (bus_req),
      .wr_en     (wr_en)
   );

   adc_dma_chan_seq #(.CH_W(CH_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .cfg_last_ch (cfg_last_ch),
      .cfg_irq_en  (cfg_irq_en),
      .ch          (adc_ch),
      .start       (adc_start),
      .irq         (irq)
   );

   adc_dma_wr_path #(
      .ADDR_W   (ADDR_W),
      .BYTE_W   (BYTE_W),
      .CH_W     (CH_W),
      .HI_FIRST (HI_FIRST)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .adc_data (adc_data),
      .second   (second),
      .cfg_base (cfg_base),
      .ch       (adc_ch),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

endmodule

// File: rtl/adc_scan_dma_chk.sv
module adc_scan_dma_chk #(
   parameter int ADDR_W = 12,
   parameter int BYTE_W = 8,
   parameter int CH_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CH_W-1:0]   adc_ch,
   input logic              adc_start,
   input logic              bus_req,
   input logic              bus_ack,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              irq
);

   AST_WR_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> bus_req);                                             // R2
   AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_en) |-> $past(bus_ack));                               // R2
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 1'b1)); // R3
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en)) |=> (!bus_req && !wr_en));              // R4
   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |=> !adc_start);                                      // R5
   AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (adc_start && adc_ch == '0));                           // R7

endmodule

bind adc_scan_dma adc_scan_dma_chk #(
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W),
   .CH_W   (CH_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .adc_ch    (adc_ch),
   .adc_start (adc_start),
   .bus_req   (bus_req),
   .bus_ack   (bus_ack),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .irq       (irq)
);

// File: tb/adc_scan_dma_tb.sv
`timescale 1ns/1ps
module adc_scan_dma_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_base = 12'h3A0;
   logic [3:0]  cfg_last_ch = 4'd3;
   logic        cfg_irq_en = 1'b1;
   logic        adc_ready = 1'b0;
   logic [15:0] adc_data = 16'h0;
   logic        bus_ack = 1'b0;
   logic [3:0]  adc_ch;
   logic        adc_start, bus_req, wr_en, irq;
   logic [11:0] wr_addr;
   logic [7:0]  wr_data;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;
   int exp_ch = 0;

   always #2.5 clk = ~clk;

   adc_scan_dma dut_i (
      .clk (clk), .rst_n (rst_n),
      .cfg_base (cfg_base), .cfg_last_ch (cfg_last_ch), .cfg_irq_en (cfg_irq_en),
      .adc_ready (adc_ready), .adc_data (adc_data),
      .adc_ch (adc_ch), .adc_start (adc_start),
      .bus_req (bus_req), .bus_ack (bus_ack),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .irq (irq)
   );

   // data[20:5], ack delay[4:1], extra ready during transfer[0]
   localparam logic [20:0] VEC [8] = '{
      {16'hA5C3, 4'd0, 1'b0},
      {16'h1234, 4'd2, 1'b1},
      {16'hFF00, 4'd1, 1'b0},
      {16'h00FF, 4'd3, 1'b1},
      {16'h8001, 4'd0, 1'b1},
      {16'h7E7E, 4'd5, 1'b0},
      {16'h0000, 4'd1, 1'b0},
      {16'hFFFF, 4'd0, 1'b1}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] d, input int dly, input bit extra);
      logic [11:0] ea;
      bit wrap;
      int nxt;
      ea   = cfg_base + 12'(2 * exp_ch);
      wrap = (exp_ch >= int'(cfg_last_ch));
      nxt  = wrap ? 0 : exp_ch + 1;
      @(negedge clk);
      adc_ready = 1'b1;
      adc_data  = d;
      @(negedge clk);
      adc_ready = 1'b0;
      adc_data  = ~d;                       // R10: late change must not matter
      chk(bus_req == 1'b1, "R2", "bus_req after ready", int'(bus_req), 1);
      chk(wr_en == 1'b0, "R2", "wr_en before ack", int'(wr_en), 0);
      for (int i = 0; i < dly; i++) begin
         @(negedge clk);
         chk(bus_req == 1'b1 && wr_en == 1'b0, "R2", "hold while no ack",
             int'({bus_req, wr_en}), 2);
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack   = 1'b0;
      adc_ready = extra;                    // R8: strobe during the transfer
      chk(wr_en == 1'b1, "R3", "first write strobe", int'(wr_en), 1);
      chk(wr_addr == ea, "R3", "high byte addr", int'(wr_addr), int'(ea));
      chk(wr_data == d[15:8], "R10", "high byte data", int'(wr_data), int'(d[15:8]));
      @(negedge clk);
      adc_ready = 1'b0;
      chk(wr_en == 1'b1, "R3", "second write strobe", int'(wr_en), 1);
      chk(wr_addr == ea + 12'd1, "R3", "low byte addr", int'(wr_addr), int'(ea + 12'd1));
      chk(wr_data == d[7:0], "R10", "low byte data", int'(wr_data), int'(d[7:0]));
      @(negedge clk);
      chk(bus_req == 1'b0 && wr_en == 1'b0, "R4", "release after writes",
          int'({bus_req, wr_en}), 0);
      chk(adc_start == 1'b1, wrap ? "R6" : "R5", "start pulse", int'(adc_start), 1);
      chk(int'(adc_ch) == nxt, wrap ? "R6" : "R5", "next channel", int'(adc_ch), nxt);
      chk(irq == (wrap && cfg_irq_en), "R7", "irq on wrap", int'(irq),
          int'(wrap && cfg_irq_en));
      @(negedge clk);
      chk(adc_start == 1'b0 && irq == 1'b0, "R5", "pulses one cycle",
          int'({adc_start, irq}), 0);
      chk(bus_req == 1'b0, "R8", "no request from ignored ready", int'(bus_req), 0);
      exp_ch = nxt;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_req == 0 && wr_en == 0 && adc_start == 0 && irq == 0, "R1",
          "outputs in reset", int'({bus_req, wr_en, adc_start, irq}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(adc_ch == 4'd0, "R1", "channel after reset", int'(adc_ch), 0);
      chk(bus_req == 0 && irq == 0, "R1", "idle after reset", int'({bus_req, irq}), 0);

      for (int v = 0; v < 8; v++)
         xfer(VEC[v][20:5], int'(VEC[v][4:1]), VEC[v][0]);

      // R7: wrap with interrupt disabled
      cfg_irq_en = 1'b0;
      while (exp_ch != 3) xfer(16'h5A5A, 0, 1'b0);
      xfer(16'hC001, 1, 1'b0);

      // R9: single-input scan
      cfg_irq_en  = 1'b1;
      cfg_last_ch = 4'd0;
      cfg_base    = 12'h7F0;
      xfer(16'hBEEF, 0, 1'b0);
      xfer(16'h4321, 2, 1'b1);
      chk(adc_ch == 4'd0, "R9", "channel stays zero", int'(adc_ch), 0);

      // R8: ready while waiting for ack
      @(negedge clk);
      adc_ready = 1'b1; adc_data = 16'h1111;
      @(negedge clk);
      adc_ready = 1'b0;
      @(negedge clk);
      adc_ready = 1'b1; adc_data = 16'h2222;
      @(negedge clk);
      adc_ready = 1'b0;
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      chk(wr_data == 8'h11, "R8", "first result kept", int'(wr_data), 8'h11);
      repeat (3) @(negedge clk);
      chk(bus_req == 1'b0 && wr_en == 1'b0, "R8", "single transfer only",
          int'({bus_req, wr_en}), 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule